// File: doc/BRIEF.md
# Class-Wise Similarity Sum and Argmax Ranker

This block turns a stream of per-entry similarity scores, produced by a key memory that compares one query against every stored support entry, into a single predicted class. Each beat of the stream carries one signed score and the class of the entry that produced it. The class is given as a one-hot vector with one bit per class of the current support set, numbered from zero. The block optionally sharpens each score by taking its absolute value, adds it into a running total kept for its class, and once the last entry of the query has arrived it selects the class whose total is largest.

Ranking on per-class sums rather than on the single best entry lets every shot of a class vote. A noisy high score on one wrong entry therefore cannot outweigh several moderately high scores on the right class. The sharpening step is chosen per beat. It is used when the key memory holds bipolar vectors, whose dot products can be negative. It is bypassed for binary vectors, whose scores never go below zero.

A query is framed by a first-entry flag on its opening beat and a last-entry flag on its closing beat. The result, holding the winning class index and its total, is registered and flagged by a one-cycle valid pulse.

Top module: `class_sum_ranker`

## Requirements
- R1: `in_label` is one-hot on every beat with `in_valid` high; bit k set means the entry belongs to class k, with classes numbered from 0 to NUM_WAYS-1.
- R2: The total of a class is the sum of the (possibly sharpened) scores of all entries of the current query labelled with that class.
- R3: The reported class is the one with the largest total, and `out_total` equals that total as a signed two's-complement number.
- R4: When several classes share the largest total, the lowest class index is reported; if all totals are zero, class 0 is reported.
- R5: With `mode_abs` = 1 on a beat, the absolute value of that beat's score is accumulated.
- R6: With `mode_abs` = 0 on a beat, the score is accumulated unchanged, sign included.
- R7: A beat with `in_first` high discards every total from earlier queries; that beat's own score is the first to count. A single beat with both flags high forms a complete query.
- R8: `out_valid` is high for exactly the one cycle after the clock edge that accepts a beat with `in_last` high; `out_class` and `out_total` keep their value until the next result.
- R9: While `in_valid` is low, `in_score`, `in_label`, `in_first`, `in_last` and `mode_abs` have no effect on any total or on the output.
- R10: Totals do not wrap when a class receives up to MAX_SHOTS entries of the most extreme score, -2^(SCORE_W-1) sharpened or not.
- R11: During and right after reset, `out_valid`, `out_class` and `out_total` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat carries a score |
| in_first | input | 1 | Beat is the first entry of a query |
| in_last | input | 1 | Beat is the last entry of a query |
| in_score | input | SCORE_W | Signed similarity score of the entry |
| in_label | input | NUM_WAYS | One-hot class of the entry |
| mode_abs | input | 1 | 1: use the absolute value of the score, 0: use it unchanged |
| out_valid | output | 1 | One-cycle pulse announcing a new result |
| out_class | output | $clog2(NUM_WAYS) | Index of the winning class |
| out_total | output | ACC_W | Signed total of the winning class |

## Verification
The bench aims at the cases where a simpler ranker would pick the wrong class. A stream in which one entry outscores each shot of another class, but loses on the sum, catches a design that takes a per-entry maximum. A strongly negative score that wins only after sharpening, replayed in pass-through mode, catches a sharpening step that is ignored or applied in the wrong mode. Equal totals at distinct indices, and an all-zero query, show whether ties go to the lowest index rather than the last one scanned. A large query followed by a small one exposes totals that are not cleared. Five shots of the most negative score at the highest class index expose a narrow accumulator or a decode that stops short of the top class. Garbage on the inputs during idle gaps, and single-beat queries, check the framing.

// File: rtl/class_sum_ranker_pkg.sv
package class_sum_ranker_pkg;

  typedef enum logic {
    SHARP_PASS = 1'b0,
    SHARP_ABS  = 1'b1
  } sharp_mode_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned total_width(input int unsigned score_w,
                                              input int unsigned max_shots);
    return score_w + 1 + $clog2(max_shots + 1);
  endfunction

endpackage

// File: rtl/csr_sharpen.sv
module csr_sharpen
  import class_sum_ranker_pkg::*;
#(
  parameter int unsigned SCORE_W = 11
) (
  input  sharp_mode_e                mode,
  input  logic signed [SCORE_W-1:0]  score,
  output logic signed [SCORE_W:0]    sharp
);

  logic signed [SCORE_W:0] score_ext;

  always_comb begin
    score_ext = {score[SCORE_W-1], score};
    if (mode == SHARP_ABS && score_ext < 0) begin
      sharp = -score_ext;
    end else begin
      sharp = score_ext;
    end
  end

endmodule

// File: rtl/csr_class_bank.sv
module csr_class_bank #(
  parameter int unsigned NUM_WAYS = 100,
  parameter int unsigned SCORE_W  = 11,
  parameter int unsigned ACC_W    = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       beat_en,
  input  logic                       clear,
  input  logic [NUM_WAYS-1:0]        label,
  input  logic signed [SCORE_W:0]    sharp,
  output logic signed [ACC_W-1:0]    acc_d [NUM_WAYS],
  output logic signed [ACC_W-1:0]    acc_q [NUM_WAYS]
);

  localparam int unsigned EXT_W = ACC_W - SCORE_W - 1;

  logic signed [ACC_W-1:0] sharp_ext;

  always_comb begin
    sharp_ext = {{EXT_W{sharp[SCORE_W]}}, sharp};
  end

  for (genvar k = 0; k < NUM_WAYS; k++) begin : g_way
    logic signed [ACC_W-1:0] base;

    always_comb begin
      base = clear ? '0 : acc_q[k];
      if (beat_en) begin
        acc_d[k] = label[k] ? (base + sharp_ext) : base;
      end else begin
        acc_d[k] = acc_q[k];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k] <= '0;
      end else if (beat_en) begin
        acc_q[k] <= acc_d[k];
      end
    end

    AST_CLEAR_UNLABELED: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && clear && !label[k]) |=> (acc_q[k] == '0)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_en && !clear && label[k] && sharp >= 0) |=> (acc_q[k] >= $past(acc_q[k]))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_en |=> $stable(acc_q[k])); // R9
  end

endmodule

// File: rtl/csr_argmax.sv
module csr_argmax #(
  parameter int unsigned NUM_WAYS = 100,
  parameter int unsigned ACC_W    = 15,
  parameter int unsigned IDX_W    = 7
) (
  input  logic signed [ACC_W-1:0] totals [NUM_WAYS],
  output logic [IDX_W-1:0]        best_idx,
  output logic signed [ACC_W-1:0] best_val
);

  always_comb begin
    best_idx = '0;
    best_val = totals[0];
    for (int k = 1; k < NUM_WAYS; k++) begin
      if (totals[k] > best_val) begin
        best_val = totals[k];
        best_idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/class_sum_ranker.sv
module class_sum_ranker
  import class_sum_ranker_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = 100,
  parameter int unsigned SCORE_W   = 11,
  parameter int unsigned MAX_SHOTS = 5,
  localparam int unsigned IDX_W    = idx_width(NUM_WAYS),
  localparam int unsigned ACC_W    = total_width(SCORE_W, MAX_SHOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic signed [SCORE_W-1:0] in_score,
  input  logic [NUM_WAYS-1:0]       in_label,
  input  logic                      mode_abs,
  output logic                      out_valid,
  output logic [IDX_W-1:0]          out_class,
  output logic signed [ACC_W-1:0]   out_total
);

  sharp_mode_e              beat_mode;
  logic signed [SCORE_W:0]  sharp;
  logic signed [ACC_W-1:0]  acc_d [NUM_WAYS];
  logic signed [ACC_W-1:0]  acc_q [NUM_WAYS];
  logic [IDX_W-1:0]         win_idx;
  logic signed [ACC_W-1:0]  win_val;
  logic                     done_beat;

  logic                     valid_d;
  logic [IDX_W-1:0]         class_d;
  logic signed [ACC_W-1:0]  total_d;

  always_comb begin
    beat_mode = mode_abs ? SHARP_ABS : SHARP_PASS;
    done_beat = in_valid && in_last;
  end

  csr_sharpen #(
    .SCORE_W (SCORE_W)
  ) i_sharpen (
    .mode  (beat_mode),
    .score (in_score),
    .sharp (sharp)
  );

  csr_class_bank #(
    .NUM_WAYS (NUM_WAYS),
    .SCORE_W  (SCORE_W),
    .ACC_W    (ACC_W)
  ) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_en (in_valid),
    .clear   (in_first),
    .label   (in_label),
    .sharp   (sharp),
    .acc_d   (acc_d),
    .acc_q   (acc_q)
  );

  csr_argmax #(
    .NUM_WAYS (NUM_WAYS),
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W)
  ) i_argmax (
    .totals   (acc_d),
    .best_idx (win_idx),
    .best_val (win_val)
  );

  always_comb begin
    valid_d = done_beat;
    class_d = out_class;
    total_d = out_total;
    if (done_beat) begin
      class_d = win_idx;
      total_d = win_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= '0;
      out_total <= '0;
    end else begin
      out_valid <= valid_d;
      if (done_beat) begin
        out_class <= class_d;
        out_total <= total_d;
      end
    end
  end

  AST_LABEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot(in_label)); // R1

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_last) |=> ($stable(out_class) && $stable(out_total))); // R8

  AST_CLASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_class) < int'(NUM_WAYS))); // R3

endmodule

// File: tb/test_class_sum_ranker.sv
`timescale 1ns/1ps
module test_class_sum_ranker;

  localparam int WAYS    = 100;
  localparam int SCORE_W = 11;
  localparam int IDX_W   = 7;
  localparam int ACC_W   = 15;

  logic                      clk;
  logic                      rst_n;
  logic                      in_valid;
  logic                      in_first;
  logic                      in_last;
  logic signed [SCORE_W-1:0] in_score;
  logic [WAYS-1:0]           in_label;
  logic                      mode_abs;
  logic                      out_valid;
  logic [IDX_W-1:0]          out_class;
  logic signed [ACC_W-1:0]   out_total;

  int total_checks = 0;
  int bad_checks   = 0;

  int q_cls[$];
  int q_score[$];
  int exp_cls_q[$];
  int exp_tot_q[$];
  string exp_req_q[$];
  int last_cls;
  int last_tot;
  bit prev_valid;

  class_sum_ranker i_class_sum_ranker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .in_score  (in_score),
    .in_label  (in_label),
    .mode_abs  (mode_abs),
    .out_valid (out_valid),
    .out_class (out_class),
    .out_total (out_total)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input int c, input int s);
    q_cls.push_back(c);
    q_score.push_back(s);
  endtask

  task automatic send_query(input bit bip, input int gap, input string req);
    int tot[WAYS];
    int best;
    int bidx;
    int n;
    n = q_cls.size();
    for (int k = 0; k < WAYS; k++) tot[k] = 0;
    for (int i = 0; i < n; i++) begin
      tot[q_cls[i]] += (bip && q_score[i] < 0) ? -q_score[i] : q_score[i];
    end
    best = tot[0];
    bidx = 0;
    for (int k = 1; k < WAYS; k++) begin
      if (tot[k] > best) begin
        best = tot[k];
        bidx = k;
      end
    end
    exp_cls_q.push_back(bidx);
    exp_tot_q.push_back(best);
    exp_req_q.push_back(req);
    last_cls = bidx;
    last_tot = best;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_last  = (i == n - 1);
      in_score = SCORE_W'(q_score[i]);
      in_label = '0;
      in_label[q_cls[i]] = 1'b1;
      mode_abs = bip;
      if (i != n - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_first = 1'b1;
          in_last  = 1'b1;
          in_score = SCORE_W'(-1024);
          in_label = {WAYS{1'b1}};
          mode_abs = ~bip;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    in_label = '0;
    q_cls.delete();
    q_score.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (prev_valid) begin
          check(1'b0, "R8", "out_valid longer than one cycle", 1, 0);
        end
        if (exp_cls_q.size() == 0) begin
          check(1'b0, "R8", "unexpected result pulse", 1, 0);
        end else begin
          int ec;
          int et;
          string rq;
          ec = exp_cls_q.pop_front();
          et = exp_tot_q.pop_front();
          rq = exp_req_q.pop_front();
          check(int'(out_class) == ec, rq, "class", int'(out_class), ec);
          check(int'(out_total) == et, rq, "total", int'(out_total), et);
        end
      end
      prev_valid = out_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    prev_valid = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
    in_score = '0;
    in_label = '0;
    mode_abs = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    check(out_class == '0, "R11", "out_class in reset", int'(out_class), 0);
    check(out_total == '0, "R11", "out_total in reset", int'(out_total), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

    // R2 R3: 5-way 1-shot, bipolar
    add(0, 100); add(1, -50); add(2, 420); add(3, 7); add(4, 300);
    send_query(1'b1, 0, "R3");

    // R5: negative score wins only after sharpening
    add(0, -400); add(1, 300); add(2, 10);
    send_query(1'b1, 0, "R5");
    // R6: same stream passes through unchanged
    add(0, -400); add(1, 300); add(2, 10);
    send_query(1'b0, 0, "R6");

    // R2: several moderate shots beat one high single entry
    add(2, 200); add(3, 500); add(2, 200); add(3, 0); add(2, 200); add(3, 0);
    send_query(1'b0, 0, "R2");

    // R4: tie between classes 7 and 4 goes to 4
    add(7, 250); add(4, 100); add(4, 150); add(9, 90);
    send_query(1'b1, 0, "R4");
    // R4: all-zero query reports class 0
    add(5, 0); add(6, 0); add(50, 0);
    send_query(1'b0, 0, "R4");

    // R7: big query followed by small one must not carry totals over
    add(9, 1000); add(9, 1000); add(9, 1000);
    send_query(1'b0, 0, "R7");
    add(1, 3); add(2, 1);
    send_query(1'b0, 0, "R7");
    // R7: single-beat query with both flags
    add(33, -77);
    send_query(1'b1, 0, "R7");

    // R10: extreme shots at the top class indices
    for (int s = 0; s < 5; s++) begin add(99, -1024); add(98, 1023); end
    send_query(1'b1, 0, "R10");
    for (int s = 0; s < 5; s++) begin add(0, -1024); end
    send_query(1'b0, 0, "R10");

    // R9: idle gaps with garbage on every input
    add(12, 40); add(13, 60); add(12, 30); add(14, -90);
    send_query(1'b1, 2, "R9");
    add(12, 40); add(13, 60); add(12, 30); add(14, -90);
    send_query(1'b0, 3, "R9");

    // R8: result held while idle
    repeat (4) @(negedge clk);
    check(int'(out_class) == last_cls, "R8", "held class", int'(out_class), last_cls);
    check(int'(out_total) == last_tot, "R8", "held total", int'(out_total), last_tot);
    check(out_valid == 1'b0, "R8", "no pulse while idle", int'(out_valid), 0);

    // R1 R2 R3: random few-shot queries, up to 100 ways and 5 shots
    for (int t = 0; t < 30; t++) begin
      int m;
      int n;
      bit bip;
      m   = (t % 3 == 0) ? 5 : ((t % 3 == 1) ? 20 : 100);
      n   = 1 + (t % 5);
      bip = t[0];
      for (int s = 0; s < n; s++) begin
        for (int c = 0; c < m; c++) begin
          if (bip) add(c, int'($urandom_range(2047)) - 1024);
          else     add(c, int'($urandom_range(1023)));
        end
      end
      send_query(bip, t % 2, "R1");
    end

    repeat (4) @(negedge clk);
    check(exp_cls_q.size() == 0, "R8", "results missing", exp_cls_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule